// File: doc/BRIEF.md
# Single-Bit Manipulation Execution Unit

This block decodes and executes the 64-bit single-bit instruction group in a single pass of combinational logic. The group has four operations: set one bit, clear one bit, invert one bit and extract one bit. It takes one 32-bit instruction word and two 64-bit source operands that have already been read from the register file. In the same cycle it reports three things: whether the word belongs to the group, whether that use is illegal, and the 64-bit result with its destination index and write enable.

Each operation has three forms. The register form takes the bit index from the second operand. The immediate form takes the index from a 6-bit field inside the instruction. The 32-bit word form works on the low half and sign-extends the result. An extension-enable input and a 64-bit-mode input decide legality. Any word outside the group is ignored and gives all-zero outputs, so a neighbouring execution unit can claim it.

Top module: `sbit_unit`

## Requirements
- R1: Register forms (opcode 0110011) are recognised as follows. Upper field inst[31:25] = 0010100 with inst[14:12] = 001 is set. 0100100 with 001 is clear. 0110100 with 001 is invert. 0100100 with 101 is extract.
- R2: Immediate forms (opcode 0010011) compare only inst[31:26], against 001010, 010010, 011010 and 010010, with the same inst[14:12] values as R1. The bit index is inst[25:20].
- R3: Word forms use opcode 0111011 (index from the operand) and 0011011 (index from inst[24:20]). Both match the full 7-bit upper field of R1. Opcode 0011011 has no extract form.
- R4: With mask = 1 shifted left by the index, set returns rs1 OR mask, clear returns rs1 AND NOT mask, and invert returns rs1 XOR mask.
- R5: Extract returns bit [index] of rs1 in result bit 0. All other result bits are zero.
- R6: Register and register-word forms take the index from rs2[5:0]. Bits rs2[63:6] have no effect on the result.
- R7: Word forms reduce the index modulo 32, so rs2 bit 5 is ignored. They copy result bit 31 into bits 63:32.
- R8: A recognised instruction is flagged illegal when the extension enable is low. A word form is also flagged illegal when the 64-bit mode input is low. In both cases valid is low and the result is zero.
- R9: A word outside the group drives claimed, valid, illegal and write-enable low and the result to zero.
- R10: rd_idx is inst[11:7]. A valid instruction still produces its result when rd_idx is 0, but rd_we is high only when valid is high and rd_idx is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inst | input | 32 | Instruction word to decode |
| src_a | input | 64 | First source operand (rs1 value) |
| src_b | input | 64 | Second source operand (rs2 value) |
| bext_en | input | 1 | Bit-manipulation extension enabled |
| rv64_mode | input | 1 | Core runs in 64-bit mode |
| claimed | output | 1 | Word belongs to the single-bit group |
| illegal | output | 1 | Claimed word is not permitted in the current mode |
| valid | output | 1 | Claimed and permitted; result is meaningful |
| rd_idx | output | 5 | Destination register index |
| rd_we | output | 1 | Destination write enable |
| result | output | 64 | Operation result, zero unless valid |

## Verification
The unit has no registers, so every output is due in the same cycle that its instruction and operands are presented. The driver applies each stimulus one time unit after a rising edge and queues the expected outputs. The monitor pops and compares them at the following falling edge, half a period later, when the logic has long settled and no edge is being processed. Only one item is in flight per cycle, so each comparison always pairs with the stimulus that is still on the inputs.

// File: rtl/sbit_pkg.sv
`timescale 1ns/1ps
package sbit_pkg;

  localparam logic [6:0] OPC_REG  = 7'b0110011;
  localparam logic [6:0] OPC_IMM  = 7'b0010011;
  localparam logic [6:0] OPC_REGW = 7'b0111011;
  localparam logic [6:0] OPC_IMMW = 7'b0011011;

  localparam logic [2:0] F3_MOD = 3'b001;
  localparam logic [2:0] F3_GET = 3'b101;

  localparam logic [6:0] UP_SET = 7'b0010100;
  localparam logic [6:0] UP_CLR = 7'b0100100;
  localparam logic [6:0] UP_INV = 7'b0110100;
  localparam logic [6:0] UP_GET = 7'b0100100;

  typedef enum logic [1:0] {BOP_SET, BOP_CLR, BOP_INV, BOP_GET} bop_e;

  typedef struct packed {
    logic hit;
    logic word;
    logic imm;
    bop_e op;
  } bdec_t;

  // Classify the upper field and funct3. When lsb_free is set, bit 0 of the
  // upper field belongs to the shift amount and is not compared.
  function automatic bdec_t classify(input logic [6:0] upper, input logic [2:0] f3,
                                     input logic lsb_free, input logic allow_get);
    bdec_t d;
    logic [6:0] u;
    d = '0;
    d.op = BOP_SET;
    u = lsb_free ? {upper[6:1], 1'b0} : upper;
    if (f3 == F3_MOD) begin
      if (u == UP_SET) begin
        d.hit = 1'b1; d.op = BOP_SET;
      end else if (u == UP_CLR) begin
        d.hit = 1'b1; d.op = BOP_CLR;
      end else if (u == UP_INV) begin
        d.hit = 1'b1; d.op = BOP_INV;
      end
    end else if (f3 == F3_GET && allow_get && u == UP_GET) begin
      d.hit = 1'b1; d.op = BOP_GET;
    end
    return d;
  endfunction

endpackage

// File: rtl/sbit_decode.sv
`timescale 1ns/1ps
module sbit_decode
  import sbit_pkg::*;
#(
  parameter int ILEN = 32
) (
  input  logic [ILEN-1:0] inst,
  output bdec_t           dec,
  output logic [4:0]      rd
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] upper;
  logic       unused_fields;

  assign opc   = inst[6:0];
  assign f3    = inst[14:12];
  assign upper = inst[31:25];
  assign rd    = inst[11:7];
  assign unused_fields = ^{inst[24:15]};

  always_comb begin
    dec = '0;
    unique case (opc)
      OPC_REG: begin
        dec = classify(upper, f3, 1'b0, 1'b1);
      end
      OPC_IMM: begin
        dec = classify(upper, f3, 1'b1, 1'b1);
        dec.imm = 1'b1;
      end
      OPC_REGW: begin
        dec = classify(upper, f3, 1'b0, 1'b1);
        dec.word = 1'b1;
      end
      OPC_IMMW: begin
        dec = classify(upper, f3, 1'b0, 1'b0);
        dec.word = 1'b1;
        dec.imm  = 1'b1;
      end
      default: dec = '0;
    endcase
  end
endmodule

// File: rtl/sbit_index.sv
`timescale 1ns/1ps
module sbit_index #(
  parameter int XLEN = 64,
  localparam int IDXW = $clog2(XLEN),
  localparam int WDXW = $clog2(XLEN / 2)
) (
  input  logic            word,
  input  logic            imm,
  input  logic [IDXW-1:0] shamt_field,
  input  logic [XLEN-1:0] src_b,
  output logic [IDXW-1:0] idx
);
  logic [IDXW-1:0] raw_idx;
  logic            unused_high;

  function automatic logic [IDXW-1:0] fold_word(input logic [IDXW-1:0] v);
    logic [IDXW-1:0] r;
    r = '0;
    r[WDXW-1:0] = v[WDXW-1:0];
    return r;
  endfunction

  assign raw_idx     = imm ? shamt_field : src_b[IDXW-1:0];
  assign idx         = word ? fold_word(raw_idx) : raw_idx;
  assign unused_high = ^src_b[XLEN-1:IDXW];
endmodule

// File: rtl/sbit_core.sv
`timescale 1ns/1ps
module sbit_core
  import sbit_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int IDXW = $clog2(XLEN)
) (
  input  bop_e            op,
  input  logic [XLEN-1:0] src_a,
  input  logic [IDXW-1:0] idx,
  output logic [XLEN-1:0] raw
);
  function automatic logic [XLEN-1:0] lane_mask(input logic [IDXW-1:0] i);
    return XLEN'(1) << i;
  endfunction

  function automatic logic [XLEN-1:0] bit_op(input bop_e o, input logic [XLEN-1:0] a,
                                             input logic [IDXW-1:0] i);
    logic [XLEN-1:0] m;
    m = lane_mask(i);
    unique case (o)
      BOP_SET: return a | m;
      BOP_CLR: return a & ~m;
      BOP_INV: return a ^ m;
      default: return XLEN'((a >> i) & XLEN'(1));
    endcase
  endfunction

  assign raw = bit_op(op, src_a, idx);
endmodule

// File: rtl/sbit_wordfix.sv
`timescale 1ns/1ps
module sbit_wordfix #(
  parameter int XLEN = 64,
  localparam int HALF = XLEN / 2
) (
  input  logic            word,
  input  logic [XLEN-1:0] raw,
  output logic [XLEN-1:0] fixed
);
  function automatic logic [XLEN-1:0] sext_half(input logic [XLEN-1:0] v);
    return {{HALF{v[HALF-1]}}, v[HALF-1:0]};
  endfunction

  assign fixed = word ? sext_half(raw) : raw;
endmodule

// File: rtl/sbit_unit.sv
`timescale 1ns/1ps
module sbit_unit
  import sbit_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int ILEN = 32,
  localparam int IDXW = $clog2(XLEN),
  localparam int HALF = XLEN / 2
) (
  input  logic [ILEN-1:0] inst,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic            bext_en,
  input  logic            rv64_mode,
  output logic            claimed,
  output logic            illegal,
  output logic            valid,
  output logic [4:0]      rd_idx,
  output logic            rd_we,
  output logic [XLEN-1:0] result
);
  bdec_t           dec;
  logic [IDXW-1:0] bit_idx;
  logic [XLEN-1:0] raw_res;
  logic [XLEN-1:0] fixed_res;
  logic            mode_block;
  logic            ext_block;

  sbit_decode #(.ILEN(ILEN)) u_dec (
    .inst (inst),
    .dec  (dec),
    .rd   (rd_idx)
  );

  sbit_index #(.XLEN(XLEN)) u_idx (
    .word        (dec.word),
    .imm         (dec.imm),
    .shamt_field (inst[20+IDXW-1:20]),
    .src_b       (src_b),
    .idx         (bit_idx)
  );

  sbit_core #(.XLEN(XLEN)) u_core (
    .op    (dec.op),
    .src_a (src_a),
    .idx   (bit_idx),
    .raw   (raw_res)
  );

  sbit_wordfix #(.XLEN(XLEN)) u_fix (
    .word  (dec.word),
    .raw   (raw_res),
    .fixed (fixed_res)
  );

  assign ext_block  = !bext_en;
  assign mode_block = dec.word && !rv64_mode;
  assign claimed    = dec.hit;
  assign illegal    = dec.hit && (ext_block || mode_block);
  assign valid      = dec.hit && !ext_block && !mode_block;
  assign rd_we      = valid && (rd_idx != 5'd0);
  assign result     = valid ? fixed_res : '0;

  always_comb begin
    // R8
    ext_gate_chk: assert (bext_en || !valid)
      else $error("valid raised with extension disabled");
    // R7
    if (valid && dec.word)
      word_sext_chk: assert (result[XLEN-1:HALF] == {HALF{result[HALF-1]}})
        else $error("word result not sign-extended");
    // R5
    if (valid && dec.op == BOP_GET)
      get_upper_chk: assert (result[XLEN-1:1] == '0)
        else $error("extract left upper bits set");
    // R9
    if (!claimed)
      idle_out_chk: assert (result == '0 && !rd_we && !valid && !illegal)
        else $error("outputs active for foreign instruction");
    // R10
    x0_write_chk: assert (!rd_we || rd_idx != 5'd0)
      else $error("write enable toward x0");
  end
endmodule

// File: tb/sbit_unit_test.sv
`timescale 1ns/1ps
module sbit_unit_test;

  typedef struct {
    logic        claimed;
    logic        illegal;
    logic        valid;
    logic        we;
    logic [4:0]  rd;
    logic [63:0] res;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] inst = 32'h0;
  logic [63:0] src_a = 64'h0, src_b = 64'h0;
  logic        bext_en = 1'b1, rv64_mode = 1'b1;
  logic        claimed, illegal, valid, rd_we;
  logic [4:0]  rd_idx;
  logic [63:0] result;

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  exp_t sb[$];

  always #4 clk = ~clk;

  sbit_unit uut (
    .inst(inst), .src_a(src_a), .src_b(src_b), .bext_en(bext_en),
    .rv64_mode(rv64_mode), .claimed(claimed), .illegal(illegal), .valid(valid),
    .rd_idx(rd_idx), .rd_we(rd_we), .result(result)
  );

  // Independent reference: decode by opcode value, compute bit by bit.
  function automatic exp_t model(input logic [31:0] i, input logic [63:0] a, input logic [63:0] b,
                                 input logic en, input logic r64, input string tag);
    exp_t        e;
    int          kind = 0;
    bit          word = 0;
    bit          imm = 0;
    int          idx;
    logic [63:0] r = 64'h0;
    logic [6:0]  hi = i[31:25];
    logic [2:0]  fn = i[14:12];
    case (i[6:0])
      7'h33, 7'h3B: begin
        word = (i[6:0] == 7'h3B);
        if (fn == 3'd1 && hi == 7'h14) kind = 1;
        if (fn == 3'd1 && hi == 7'h24) kind = 2;
        if (fn == 3'd1 && hi == 7'h34) kind = 3;
        if (fn == 3'd5 && hi == 7'h24) kind = 4;
      end
      7'h13: begin
        imm = 1;
        if (fn == 3'd1 && hi[6:1] == 6'h0A) kind = 1;
        if (fn == 3'd1 && hi[6:1] == 6'h12) kind = 2;
        if (fn == 3'd1 && hi[6:1] == 6'h1A) kind = 3;
        if (fn == 3'd5 && hi[6:1] == 6'h12) kind = 4;
      end
      7'h1B: begin
        imm = 1; word = 1;
        if (fn == 3'd1 && hi == 7'h14) kind = 1;
        if (fn == 3'd1 && hi == 7'h24) kind = 2;
        if (fn == 3'd1 && hi == 7'h34) kind = 3;
      end
      default: kind = 0;
    endcase
    idx = imm ? int'(i[25:20]) : int'(b[5:0]);
    if (word) idx = idx % 32;
    for (int k = 0; k < 64; k++) begin
      case (kind)
        1: r[k] = (k == idx) ? 1'b1 : a[k];
        2: r[k] = (k == idx) ? 1'b0 : a[k];
        3: r[k] = (k == idx) ? ~a[k] : a[k];
        4: r[k] = (k == 0) ? a[idx] : 1'b0;
        default: r[k] = 1'b0;
      endcase
    end
    if (word) for (int k = 32; k < 64; k++) r[k] = r[31];
    e.claimed = (kind != 0);
    e.illegal = e.claimed && (!en || (word && !r64));
    e.valid   = e.claimed && !e.illegal;
    e.res     = e.valid ? r : 64'h0;
    e.rd      = i[11:7];
    e.we      = e.valid && (i[11:7] != 5'd0);
    e.tag     = tag;
    return e;
  endfunction

  // Forms: 0-3 register, 4-7 immediate, 8-11 register word, 12-14 immediate word.
  function automatic logic [31:0] form_inst(input int f, input int idx, input logic [4:0] rd);
    int         op = (f < 12) ? (f % 4) : (f - 12);
    logic [6:0] u7 = (op == 0) ? 7'h14 : (op == 2) ? 7'h34 : 7'h24;
    logic [2:0] f3 = (op == 3) ? 3'd5 : 3'd1;
    logic [5:0] s6 = 6'(idx);
    if (f < 4)       return {u7, 5'd7, 5'd3, f3, rd, 7'h33};
    else if (f < 8)  return {u7[6:1], s6, 5'd3, f3, rd, 7'h13};
    else if (f < 12) return {u7, 5'd7, 5'd3, f3, rd, 7'h3B};
    else             return {u7, s6[4:0], 5'd3, f3, rd, 7'h1B};
  endfunction

  function automatic string form_tag(input int f);
    int    op = (f < 12) ? (f % 4) : (f - 12);
    string s = (f < 4) ? "R1 R6" : (f < 8) ? "R2" : "R3 R7";
    return {s, (op == 3) ? " R5" : " R4"};
  endfunction

  task automatic drive(input logic [31:0] i, input logic [63:0] a, input logic [63:0] b,
                       input logic en, input logic r64, input string tag);
    @(posedge clk);
    #1;
    inst = i; src_a = a; src_b = b; bext_en = en; rv64_mode = r64;
    sb.push_back(model(i, a, b, en, r64, tag));
  endtask

  // Monitor: results are combinational, due half a period after the drive.
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (claimed !== e.claimed || illegal !== e.illegal || valid !== e.valid ||
            rd_we !== e.we || rd_idx !== e.rd || result !== e.res) begin
          errors++;
          $display("FAIL %s inst=%h: got c%b i%b v%b we%b rd%0d res=%h, expected c%b i%b v%b we%b rd%0d res=%h",
                   e.tag, inst, claimed, illegal, valid, rd_we, rd_idx, result,
                   e.claimed, e.illegal, e.valid, e.we, e.rd, e.res);
        end
      end
    end
  end

  initial begin
    #1200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int idxs[4] = '{0, 31, 32, 63};
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R9: idle state after reset, all-zero word
    drive(32'h0, 64'h0, 64'h0, 1'b1, 1'b1, "R9 reset");
    // R1 R2 R3 R4 R5 R7: every form, boundary indices, random operands
    for (int f = 0; f < 15; f++) begin
      foreach (idxs[n]) begin
        for (int rep = 0; rep < 4; rep++) begin
          logic [63:0] a = {$urandom, $urandom};
          logic [63:0] b = {$urandom, $urandom};
          logic [4:0]  rd = 5'($urandom_range(1, 31));
          if (rep == 3) a = ~a;
          b[5:0] = 6'(idxs[n]);
          drive(form_inst(f, idxs[n], rd), a, b, 1'b1, 1'b1, form_tag(f));
        end
      end
    end
    // R7: word forms with rs2 bit 5 set and random low bits
    for (int f = 8; f < 12; f++)
      for (int rep = 0; rep < 4; rep++)
        drive(form_inst(f, 0, 5'd9), {$urandom, $urandom},
              {$urandom, $urandom} | 64'h20, 1'b1, 1'b1, "R7 bit5");
    // R6: upper rs2 bits ignored
    drive(form_inst(0, 0, 5'd4), 64'h0, 64'hFFFF_FFFF_FFFF_FFC5, 1'b1, 1'b1, "R6 set");
    drive(form_inst(3, 0, 5'd4), 64'h0000_0000_0000_0020, 64'hABCD_0000_0000_0045, 1'b1, 1'b1, "R6 get");
    // R8: extension disabled, and 32-bit mode
    for (int f = 0; f < 15; f++)
      drive(form_inst(f, 5, 5'd2), {$urandom, $urandom}, 64'd5, 1'b0, 1'b1, "R8 ext off");
    for (int f = 0; f < 15; f++)
      drive(form_inst(f, 7, 5'd2), {$urandom, $urandom}, 64'd7, 1'b1, 1'b0, "R8 rv32");
    // R9: neighbouring encodings that must not be claimed
    drive({7'h00, 5'd7, 5'd3, 3'd0, 5'd1, 7'h33}, 64'hF, 64'h1, 1'b1, 1'b1, "R9 add");
    drive({7'h00, 5'd7, 5'd3, 3'd1, 5'd1, 7'h33}, 64'hF, 64'h1, 1'b1, 1'b1, "R9 sll");
    drive({7'h14, 5'd7, 5'd3, 3'd5, 5'd1, 7'h33}, 64'hF, 64'h1, 1'b1, 1'b1, "R9 f3 mix");
    drive({7'h24, 5'd7, 5'd3, 3'd5, 5'd1, 7'h1B}, 64'hF, 64'h1, 1'b1, 1'b1, "R9 R3 no imm word get");
    drive({7'h15, 5'd7, 5'd3, 3'd1, 5'd1, 7'h1B}, 64'hF, 64'h1, 1'b1, 1'b1, "R9 R3 word lsb");
    drive({6'h0B, 6'd3, 5'd3, 3'd1, 5'd1, 7'h13}, 64'hF, 64'h1, 1'b1, 1'b1, "R9 imm upper");
    drive({7'h24, 5'd7, 5'd3, 3'd1, 5'd1, 7'h63}, 64'hF, 64'h1, 1'b1, 1'b1, "R9 branch");
    // R10: destination x0 still produces a result but no write
    drive(form_inst(0, 3, 5'd0), 64'h0, 64'd3, 1'b1, 1'b1, "R10 x0");
    drive(form_inst(6, 40, 5'd0), 64'h0, 64'd0, 1'b1, 1'b1, "R10 x0 imm");
    drive(form_inst(1, 3, 5'd31), 64'hFF, 64'd3, 1'b1, 1'b1, "R10 x31");
    while (sb.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule